// File: doc/BRIEF.md
# Display RAM Host Bus Interface

This block connects an 8-bit parallel host bus to a small display data RAM held inside the block. The host uses two chip selects (one active low, one active high), a line that picks command/status access or display-data access, and separate active-low read and write strobes. Each strobe acts on its rising edge, after the edge has been synchronised to the internal clock.

A single holding register sits between the bus and the RAM. A data write loads this register first and commits it to RAM one cycle later. A data read puts the register's current contents on the bus. The register is then refilled from RAM at the column pointer. As a result, the first read after an address change or after a write returns stale data, and the host must perform one dummy read. Every data access advances the column pointer, which wraps to zero after the last column. A status read reports a busy flag on the top data bit. Deselecting the block also holds a serial-port reset line active.

The controller is a four-state machine. ST_IDLE waits for a strobe edge. ST_COMMIT writes the holding register to RAM. ST_FETCH issues a synchronous RAM read. ST_LOAD captures the read word into the holding register. The transitions are:
- ST_IDLE goes to ST_COMMIT on a data write edge.
- ST_IDLE goes to ST_FETCH on a data read edge, when no write edge arrives in the same cycle.
- ST_COMMIT goes to ST_IDLE.
- ST_FETCH goes to ST_LOAD.
- ST_LOAD goes to ST_IDLE.
- Command writes and status reads keep the machine in ST_IDLE.

Top module: `dbi_host_if`

## Requirements
- R1: The block is selected only when cs1_n = 0 and cs2 = 1. In any other combination, host_doe stays 0, host_dout is 0, and read and write strobes change neither the RAM nor the column pointer nor the holding register.
- R2: ser_rst is 1 exactly while the block is deselected.
- R3: While selected with a0 = 1 and rd_n = 0, the block drives the holding register on host_dout with host_doe = 1. After the rd_n rising edge, it loads the holding register from RAM at the column pointer and advances the pointer.
- R4: The first data read after an address set returns the holding register's previous contents. The following read returns the RAM word at the address that was set.
- R5: A data write (a0 = 1) loads host_din into the holding register on the wr_n rising edge. The next cycle writes it to RAM at the column pointer and advances the pointer.
- R6: A data read right after a data write returns the byte just written (the holding register contents), not RAM data.
- R7: The column pointer steps N, N+1, ... after every data read or write and wraps from COLUMNS-1 to 0.
- R8: A status read (a0 = 0, rd_n = 0) drives the busy flag on bit 7 and zeros on bits 6..0.
- R9: Busy is 1 while the state machine is out of ST_IDLE. It also stays 1 for BUSY_CYCLES clocks after each command write or RAM commit, and then returns to 0.
- R10: A command write with bit 7 = 1 is an address set. It loads the column pointer from bits 5..0, and a value of COLUMNS or more loads 0. A command with bit 7 = 0 changes nothing but busy. No command write touches the holding register.
- R11: After reset, the column pointer and the holding register are 0, busy is 0, and the state is ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| a0 | input | 1 | 0 = command/status, 1 = display data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| host_din | input | 8 | Data from host |
| host_dout | output | 8 | Data to host, 0 when not driving |
| host_doe | output | 1 | Output enable; 0 means the pad is high-impedance |
| ser_rst | output | 1 | Holds the serial shift register and bit counter in reset |

## Verification
The assertions assume that the host keeps a0, host_din and the chip selects stable from the falling edge of a strobe until several clocks after its rising edge. They also assume that read and write strobes are never low together, and that successive accesses are separated by more clocks than the synchroniser and state machine need. The bench drives every access through a task that holds each strobe low for four clocks and keeps the bus stable afterwards. It then idles longer than the busy window, except in the two busy-flag checks, which deliberately read status inside that window. The expected read values come from a small model of the holding register, column pointer and RAM, kept in the bench and written from the requirements.

// File: rtl/dbi_pkg.sv
`timescale 1ns/1ps
package dbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FETCH  = 2'd2,
        ST_LOAD   = 2'd3
    } dbi_state_e;

endpackage

// File: rtl/dbi_pin_sync.sv
`timescale 1ns/1ps
module dbi_pin_sync #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_in,
    input  logic              a0_in,
    input  logic              rd_n_in,
    input  logic              wr_n_in,
    input  logic [DATA_W-1:0] din_in,
    output logic              sel_s,
    output logic              a0_s,
    output logic [DATA_W-1:0] din_s,
    output logic              rd_rise,
    output logic              wr_rise
);

    localparam int W      = DATA_W + 4;
    localparam int B_WR   = DATA_W;
    localparam int B_RD   = DATA_W + 1;
    localparam int B_A0   = DATA_W + 2;
    localparam int B_SEL  = DATA_W + 3;
    localparam logic [W-1:0] IDLE_VAL = {2'b00, 2'b11, {DATA_W{1'b0}}};

    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             last;
    logic                     rd_d;
    logic                     wr_d;

    assign last = pipe[STAGES-1];

    // all pins pass through the same number of stages so data lines up with strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{IDLE_VAL}};
            rd_d <= 1'b1;
            wr_d <= 1'b1;
        end else begin
            pipe[0] <= {sel_in, a0_in, rd_n_in, wr_n_in, din_in};
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            rd_d <= last[B_RD];
            wr_d <= last[B_WR];
        end
    end

    always_comb begin
        sel_s   = last[B_SEL];
        a0_s    = last[B_A0];
        din_s   = last[DATA_W-1:0];
        rd_rise = last[B_SEL] & last[B_RD] & ~rd_d;
        wr_rise = last[B_SEL] & last[B_WR] & ~wr_d;
    end

    // R1: a strobe edge seen while deselected must never leak through
    a_r1_edge_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!last[B_SEL] && last[B_WR] && !wr_d) |-> !wr_rise);

endmodule

// File: rtl/dbi_ram.sv
`timescale 1ns/1ps
module dbi_ram #(
    parameter int DATA_W  = 8,
    parameter int COLUMNS = 40,
    parameter int COL_W   = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [COL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [COLUMNS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/dbi_bus_ctrl.sv
`timescale 1ns/1ps
module dbi_bus_ctrl
    import dbi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int COLUMNS     = 40,
    parameter int COL_W       = 6,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a0_s,
    input  logic [DATA_W-1:0] din_s,
    input  logic              rd_rise,
    input  logic              wr_rise,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic [COL_W-1:0]  ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [COL_W-1:0]  ram_raddr,
    output logic [DATA_W-1:0] holder,
    output logic              busy
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0]    BUSY_LOAD = BW'(BUSY_CYCLES);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(COLUMNS - 1);
    localparam logic [COL_W:0]   COL_LIM   = (COL_W+1)'(COLUMNS);

    dbi_state_e       state;
    dbi_state_e       state_nx;
    logic [COL_W-1:0] col;
    logic [COL_W-1:0] col_inc;
    logic [BW-1:0]    busy_cnt;
    logic             is_addr_cmd;
    logic [COL_W-1:0] cmd_col;

    assign col_inc     = (col == LAST_COL) ? '0 : col + 1'b1;
    assign is_addr_cmd = din_s[DATA_W-1];
    assign cmd_col     = ({1'b0, din_s[COL_W-1:0]} < COL_LIM) ? din_s[COL_W-1:0] : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_rise && a0_s) begin
                    state_nx = ST_COMMIT;
                end else if (!wr_rise && rd_rise && a0_s) begin
                    state_nx = ST_FETCH;
                end
            end
            ST_COMMIT: state_nx = ST_IDLE;
            ST_FETCH:  state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // holder, column pointer and busy timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            holder   <= '0;
            col      <= '0;
            busy_cnt <= '0;
        end else begin
            if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (wr_rise && a0_s) begin
                        holder <= din_s;
                    end else if (wr_rise && !a0_s) begin
                        busy_cnt <= BUSY_LOAD;
                        if (is_addr_cmd) begin
                            col <= cmd_col;
                        end
                    end
                end
                ST_COMMIT: begin
                    col      <= col_inc;
                    busy_cnt <= BUSY_LOAD;
                end
                ST_FETCH: begin
                end
                ST_LOAD: begin
                    holder <= ram_rdata;
                    col    <= col_inc;
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_we    = (state == ST_COMMIT);
        ram_waddr = col;
        ram_wdata = holder;
        ram_raddr = col;
        busy      = (state != ST_IDLE) || (busy_cnt != '0);
    end

    a_r7_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        col <= LAST_COL);

    a_r7_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_COMMIT || $past(state) == ST_LOAD) |->
            (col == (($past(col) == LAST_COL) ? '0 : COL_W'($past(col) + 1'b1))));

    a_r10_cmd_keeps_holder: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_rise && !a0_s) |=> $stable(holder));

    a_r5_write_to_holder: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_rise && a0_s) |=> (state == ST_COMMIT && holder == $past(din_s)));

    a_r9_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_COMMIT) |-> busy);

endmodule

// File: rtl/dbi_host_if.sv
`timescale 1ns/1ps
module dbi_host_if #(
    parameter int DATA_W      = 8,
    parameter int COLUMNS     = 40,
    parameter int BUSY_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              a0,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              ser_rst
);

    localparam int COL_W = $clog2(COLUMNS);

    logic              sel_raw;
    logic              sel_s;
    logic              a0_s;
    logic [DATA_W-1:0] din_s;
    logic              rd_rise;
    logic              wr_rise;
    logic              ram_we;
    logic [COL_W-1:0]  ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic [COL_W-1:0]  ram_raddr;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] holder;
    logic              busy;

    assign sel_raw = ~cs1_n & cs2;

    dbi_pin_sync #(
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (sel_raw),
        .a0_in   (a0),
        .rd_n_in (rd_n),
        .wr_n_in (wr_n),
        .din_in  (host_din),
        .sel_s   (sel_s),
        .a0_s    (a0_s),
        .din_s   (din_s),
        .rd_rise (rd_rise),
        .wr_rise (wr_rise)
    );

    dbi_bus_ctrl #(
        .DATA_W      (DATA_W),
        .COLUMNS     (COLUMNS),
        .COL_W       (COL_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .a0_s      (a0_s),
        .din_s     (din_s),
        .rd_rise   (rd_rise),
        .wr_rise   (wr_rise),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ram_raddr (ram_raddr),
        .holder    (holder),
        .busy      (busy)
    );

    dbi_ram #(
        .DATA_W  (DATA_W),
        .COLUMNS (COLUMNS),
        .COL_W   (COL_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // bus drive follows the pins directly, like an asynchronous read port
    always_comb begin
        host_doe  = sel_raw & ~rd_n;
        host_dout = '0;
        if (host_doe) begin
            host_dout = a0 ? holder : {busy, {(DATA_W-1){1'b0}}};
        end
        ser_rst = ~sel_raw;
    end

    a_r8_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_doe && !a0) |-> (host_dout[DATA_W-2:0] == '0));

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rst |-> (!host_doe && host_dout == '0));

    a_r3_data_shows_holder: assert property (@(posedge clk) disable iff (!rst_n)
        (host_doe && a0) |-> (host_dout == holder));

endmodule

// File: tb/test_dbi_host_if.sv
`timescale 1ns/1ps
module test_dbi_host_if;

    localparam int COLS  = 40;
    localparam int BUSYC = 16;
    localparam int GAP   = BUSYC + 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs1_n = 1'b0;
    logic       cs2 = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       doe;
    logic       ser_rst;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;

    logic [7:0] m_mem [COLS];
    logic [7:0] m_hold;
    int         m_col;

    always #2.5 clk = ~clk;

    dbi_host_if #(
        .DATA_W      (8),
        .COLUMNS     (COLS),
        .BUSY_CYCLES (BUSYC),
        .SYNC_STAGES (2)
    ) i_dbi_host_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .a0        (a0),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .host_din  (din),
        .host_dout (dout),
        .host_doe  (doe),
        .ser_rst   (ser_rst)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int nxt(input int c);
        return (c == COLS - 1) ? 0 : c + 1;
    endfunction

    task automatic wr_cycle(input logic a, input logic [7:0] d, input int wait_after);
        @(negedge clk);
        a0 = a; din = d; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (wait_after) @(negedge clk);
    endtask

    task automatic rd_cycle(input logic a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        a0 = a; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        d = dout; oe = doe;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    // model-tracked host operations (selected)
    task automatic m_write(input logic [7:0] d);
        wr_cycle(1'b1, d, GAP);
        m_hold = d; m_mem[m_col] = d; m_col = nxt(m_col);
    endtask

    task automatic m_cmd(input logic [7:0] d);
        wr_cycle(1'b0, d, GAP);
        if (d[7]) m_col = (int'(d[5:0]) < COLS) ? int'(d[5:0]) : 0;
    endtask

    task automatic m_read(input string req);
        logic [7:0] d;
        logic       oe;
        rd_cycle(1'b1, d, oe);
        check(req, {23'd0, oe, d}, {23'd0, 1'b1, m_hold});
        m_hold = m_mem[m_col]; m_col = nxt(m_col);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        m_hold = 8'h00; m_col = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: reset state
        check("R11 doe", {31'd0, doe}, 0);
        check("R11 dout", {24'd0, dout}, 0);
        rd_cycle(1'b0, d, oe);
        check("R11 R8 status after reset", {24'd0, d}, 8'h00);
        // first data read shows reset holder 0 (R11), loads RAM[0]
        rd_cycle(1'b1, d, oe);
        check("R11 holder", {24'd0, d}, 0);
        m_col = 1;

        // R5 R7: fill every column, run past the end to test the wrap
        m_cmd(8'h80);
        for (int i = 0; i < COLS + 2; i++) m_write(8'((i * 7 + 3) & 8'hff));
        check("R7 col after wrap", m_col, 2);

        // R4: after address set, first read is stale, then RAM data
        m_cmd(8'h80);
        m_read("R4 R6 stale first read");
        for (int i = 0; i < COLS; i++) m_read("R3 R5 R7 readback");
        check("R7 wrapped model", {24'd0, m_mem[0]}, ((COLS * 7 + 3) & 8'hff));

        // R6: read right after write returns written byte
        m_cmd(8'h80 | 8'd10);
        m_write(8'h5A);
        m_read("R6 read after write");
        m_read("R6 following read");

        // R10: out-of-range address loads 0; non-address command changes nothing
        m_cmd(8'h80 | 8'd45);
        m_read("R10 out-of-range dummy");
        m_read("R10 out-of-range col0");
        m_cmd(8'h12);
        m_read("R10 plain command keeps holder");
        m_read("R10 plain command keeps col");

        // R8 R9: busy window after command and after write commit
        wr_cycle(1'b0, 8'h12, 2);
        rd_cycle(1'b0, d, oe);
        check("R9 busy after command", {24'd0, d}, 8'h80);
        check("R8 status doe", {31'd0, oe}, 1);
        rd_cycle(1'b0, d, oe);
        check("R9 busy cleared", {24'd0, d}, 8'h00);
        m_cmd(8'h80 | 8'd20);
        wr_cycle(1'b1, 8'hC3, 2);
        m_hold = 8'hC3; m_mem[m_col] = 8'hC3; m_col = nxt(m_col);
        rd_cycle(1'b0, d, oe);
        check("R9 busy after commit", {24'd0, d}, 8'h80);

        // R1 R2: deselected combinations ignore strobes
        m_cmd(8'h80 | 8'd5);
        m_write(8'hA5);
        m_cmd(8'h80 | 8'd5);
        for (int k = 0; k < 4; k++) begin
            cs1_n = k[0]; cs2 = k[1];
            @(negedge clk);
            check("R2 ser_rst", {31'd0, ser_rst}, (k == 2) ? 0 : 1);
            if (k != 2) begin
                rd_cycle(1'b1, d, oe);
                check("R1 released", {23'd0, oe, d}, 0);
                wr_cycle(1'b1, 8'h3C, GAP);
                wr_cycle(1'b0, 8'h89, GAP);
            end
        end
        cs1_n = 1'b0; cs2 = 1'b1;
        @(negedge clk);
        m_read("R1 dummy after deselect");
        m_read("R1 RAM and col untouched");
        check("R1 model col5 value", {24'd0, m_mem[5]}, 8'hA5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule